// File: doc/BRIEF.md
# Character-Based Raster Timing Generator

This block produces the raster timing for one display head: horizontal and vertical sync, horizontal and vertical blank, a display-enable qualifier, the number of the scanline being drawn, and a small status byte whose retrace bit software polls. It runs from the pixel clock. Horizontal positions are counted in character cells of `DOTS` pixels. Vertical positions are counted in scanlines.

The timing fields are written through a simple address/data port, and they use the compact offset encoding of legacy graphics controllers. The horizontal total is stored as cells minus five and the vertical total as lines minus two. Display ends are stored as the last visible index. The sync-end and blank-end fields keep only their low bits, and the block finds each end by matching the low bits of the running counter. Software normally sets the horizontal blank end to the encoded total plus 4 and the vertical blank end to the encoded total plus 1.

Timing writes go into a pending copy and take effect as a whole at the next frame boundary, so a write in the middle of a frame cannot produce a malformed frame. Control writes act on the next clock. These cover sync polarity, the per-direction sync disables and screen blanking.

Top module: `crtc_timing_gen`

## Requirements
- R1: While reset is held and directly after it, both counters are zero. The loaded default timing is htot 5, hdend 5, hbstart 5, hbend 9, hsstart 6, hsend 8, vtot 10, vdend 7, vbstart 7, vbend 11, vsstart 8 and vsend 10, and control is 0. As a result de_o=1, hsync_o=0, vsync_o=0, hblank_o=0, vblank_o=0, line_o=0 and status_o=0.
- R2: A line lasts htot+5 cells of DOTS clocks. Cells are numbered 0 to htot+4. de_o is high only in cells 0 to hdend of lines 0 to vdend.
- R3: hblank_o rises at the end of the cell equal to hbstart. It falls at the end of the cell whose low 7 bits equal the 7-bit hbend. When both match in the same cell, the end wins.
- R4: hsync is active from the end of the cell equal to hsstart until the end of the cell whose low 5 bits equal hsend. Only 5 bits of hsend are kept. When both match in the same cell, the end wins.
- R5: A frame lasts vtot+2 lines. line_o shows the low 11 bits of the current line and steps by one at each line end, returning to 0 after line vtot+1.
- R6: vblank_o rises at the end of line vbstart. It falls at the end of the line whose low 8 bits equal the 8-bit vbend.
- R7: vsync is active from the end of line vsstart until the end of the line whose low 4 bits equal the 4-bit vsend.
- R8: Control bit 6 set makes hsync_o active-low. Control bit 7 set makes vsync_o active-low.
- R9: Control bit 0 holds hsync_o at its inactive level. Control bit 1 does the same for vsync_o. Control bit 2 forces de_o low. None of these bits changes blanking or the counters.
- R10: status_o bit 3 is high during the vertical sync interval, whether or not vsync is disabled. Bit 0 is high outside the display area. All other bits are 0.
- R11: A timing write is held pending and applied at the clock that ends the last cell of the last line. A control write acts from the next clock.
- R12: The write addresses are 0 htot, 1 hdend, 2 hbstart, 3 hbend, 4 hsstart, 5 hsend, 6 vtot, 7 vdend, 8 vbstart, 9 vbend, 10 vsstart, 11 vsend and 12 control. Each field takes the low bits of wr_data: 9 bits for horizontal values and 11 bits for vertical values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| hblank_o | output | 1 | Horizontal blank |
| vblank_o | output | 1 | Vertical blank |
| de_o | output | 1 | Display enable |
| line_o | output | 11 | Current scanline |
| status_o | output | 8 | Status: bit 3 retrace, bit 0 outside display |

## Verification
The bench first runs the default small frame, which shows whether each edge of the counter windows lands on the right cell and line. It then changes the sync polarity, which separates the raw sync interval from the polarity inversion. Next it applies the disables and screen blanking, which show that the gates act alone and that the retrace status keeps running underneath them. Last, it writes a larger timing in the middle of a frame, with extra high bits in every truncated end field. This pattern tells frame-boundary loading apart from immediate loading, and low-bit matching apart from full-width matching.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
    localparam int HREG_W = 9;
    localparam int HCNT_W = HREG_W + 1;
    localparam int HBE_W  = 7;
    localparam int HSE_W  = 5;
    localparam int VREG_W = 11;
    localparam int VCNT_W = VREG_W + 1;
    localparam int VBE_W  = 8;
    localparam int VSE_W  = 4;
    localparam int DOT_N  = 8;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;
    localparam int STAT_W = 8;

    // control bit positions
    localparam int CB_HOFF   = 0;
    localparam int CB_VOFF   = 1;
    localparam int CB_SCROFF = 2;
    localparam int CB_HNEG   = 6;
    localparam int CB_VNEG   = 7;

    // status bit positions
    localparam int SB_NODISP  = 0;
    localparam int SB_RETRACE = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_HTOT = 4'd0, RA_HDEND = 4'd1, RA_HBSTART = 4'd2, RA_HBEND = 4'd3,
        RA_HSSTART = 4'd4, RA_HSEND = 4'd5, RA_VTOT = 4'd6, RA_VDEND = 4'd7,
        RA_VBSTART = 4'd8, RA_VBEND = 4'd9, RA_VSSTART = 4'd10, RA_VSEND = 4'd11,
        RA_CTRL = 4'd12
    } crtc_addr_e;

    typedef struct packed {
        logic [HREG_W-1:0] htot;
        logic [HREG_W-1:0] hdend;
        logic [HREG_W-1:0] hbstart;
        logic [HBE_W-1:0]  hbend;
        logic [HREG_W-1:0] hsstart;
        logic [HSE_W-1:0]  hsend;
        logic [VREG_W-1:0] vtot;
        logic [VREG_W-1:0] vdend;
        logic [VREG_W-1:0] vbstart;
        logic [VBE_W-1:0]  vbend;
        logic [VREG_W-1:0] vsstart;
        logic [VSE_W-1:0]  vsend;
    } crtc_timing_t;

    typedef struct packed {
        logic vneg;
        logic hneg;
        logic scr_off;
        logic vs_off;
        logic hs_off;
    } crtc_ctrl_t;

    localparam crtc_timing_t TIMING_DEF = '{
        htot: 9'd5, hdend: 9'd5, hbstart: 9'd5, hbend: 7'd9,
        hsstart: 9'd6, hsend: 5'd8,
        vtot: 11'd10, vdend: 11'd7, vbstart: 11'd7, vbend: 8'd11,
        vsstart: 11'd8, vsend: 4'd10
    };

    function automatic crtc_ctrl_t ctrl_decode(input logic [DATA_W-1:0] d);
        crtc_ctrl_t c;
        c.hs_off  = d[CB_HOFF];
        c.vs_off  = d[CB_VOFF];
        c.scr_off = d[CB_SCROFF];
        c.hneg    = d[CB_HNEG];
        c.vneg    = d[CB_VNEG];
        return c;
    endfunction
endpackage

// File: rtl/crtc_regs.sv
module crtc_regs
    import crtc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                frame_end,
    output crtc_timing_t        act_o,
    output crtc_ctrl_t          ctrl_o
);
    crtc_timing_t pend_q, act_q;
    crtc_ctrl_t   ctrl_q;
    logic         unused_hi;

    assign unused_hi = ^wr_data[DATA_W-1:VREG_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= TIMING_DEF;
            act_q  <= TIMING_DEF;
            ctrl_q <= '0;
        end else begin
            if (frame_end)
                act_q <= pend_q;
            if (wr_en) begin
                case (crtc_addr_e'(wr_addr))
                    RA_HTOT:    pend_q.htot    <= wr_data[HREG_W-1:0];
                    RA_HDEND:   pend_q.hdend   <= wr_data[HREG_W-1:0];
                    RA_HBSTART: pend_q.hbstart <= wr_data[HREG_W-1:0];
                    RA_HBEND:   pend_q.hbend   <= wr_data[HBE_W-1:0];
                    RA_HSSTART: pend_q.hsstart <= wr_data[HREG_W-1:0];
                    RA_HSEND:   pend_q.hsend   <= wr_data[HSE_W-1:0];
                    RA_VTOT:    pend_q.vtot    <= wr_data[VREG_W-1:0];
                    RA_VDEND:   pend_q.vdend   <= wr_data[VREG_W-1:0];
                    RA_VBSTART: pend_q.vbstart <= wr_data[VREG_W-1:0];
                    RA_VBEND:   pend_q.vbend   <= wr_data[VBE_W-1:0];
                    RA_VSSTART: pend_q.vsstart <= wr_data[VREG_W-1:0];
                    RA_VSEND:   pend_q.vsend   <= wr_data[VSE_W-1:0];
                    RA_CTRL:    ctrl_q         <= ctrl_decode(wr_data);
                    default: ;
                endcase
            end
        end
    end

    assign act_o  = act_q;
    assign ctrl_o = ctrl_q;
endmodule

// File: rtl/crtc_axis.sv
module crtc_axis #(
    parameter int REG_W = 9,
    parameter int CNT_W = REG_W + 1,
    parameter int BE_W  = 7,
    parameter int SE_W  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic [CNT_W-1:0] last,
    input  logic [REG_W-1:0] dend,
    input  logic [REG_W-1:0] bstart,
    input  logic [BE_W-1:0]  bend,
    input  logic [REG_W-1:0] sstart,
    input  logic [SE_W-1:0]  send,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o,
    output logic             active_o,
    output logic             blank_o,
    output logic             sync_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             blank_q, sync_q;
    logic             hit_bs, hit_be, hit_ss, hit_se;

    assign wrap_o   = adv && (cnt_q == last);
    assign active_o = (cnt_q <= CNT_W'(dend));
    assign hit_bs   = (cnt_q == CNT_W'(bstart));
    assign hit_be   = (cnt_q[BE_W-1:0] == bend);
    assign hit_ss   = (cnt_q == CNT_W'(sstart));
    assign hit_se   = (cnt_q[SE_W-1:0] == send);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            blank_q <= 1'b0;
            sync_q  <= 1'b0;
        end else if (adv) begin
            cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
            if (hit_be)      blank_q <= 1'b0;
            else if (hit_bs) blank_q <= 1'b1;
            if (hit_se)      sync_q  <= 1'b0;
            else if (hit_ss) sync_q  <= 1'b1;
        end
    end

    assign cnt_o   = cnt_q;
    assign blank_o = blank_q;
    assign sync_o  = sync_q;
endmodule

// File: rtl/crtc_timing_gen.sv
module crtc_timing_gen
    import crtc_pkg::*;
#(
    parameter int DOTS = DOT_N
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic                hsync_o,
    output logic                vsync_o,
    output logic                hblank_o,
    output logic                vblank_o,
    output logic                de_o,
    output logic [VREG_W-1:0]   line_o,
    output logic [STAT_W-1:0]   status_o
);
    localparam int DW = (DOTS > 1) ? $clog2(DOTS) : 1;

    crtc_timing_t      act;
    crtc_ctrl_t        ctrl_q;
    logic [DW-1:0]     dot_q;
    logic              dot_last;
    logic [HCNT_W-1:0] h_last, h_cnt;
    logic [VCNT_W-1:0] v_last, v_cnt;
    logic              h_wrap, v_wrap, h_act, v_act;
    logic              h_blank, v_blank, h_sync, v_sync, disp;

    assign dot_last = (dot_q == DW'(DOTS - 1));
    assign h_last   = HCNT_W'(act.htot) + HCNT_W'(4);
    assign v_last   = VCNT_W'(act.vtot) + VCNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst)           dot_q <= '0;
        else if (dot_last) dot_q <= '0;
        else               dot_q <= dot_q + 1'b1;
    end

    crtc_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .frame_end(v_wrap), .act_o(act), .ctrl_o(ctrl_q)
    );

    crtc_axis #(.REG_W(HREG_W), .CNT_W(HCNT_W), .BE_W(HBE_W), .SE_W(HSE_W)) u_hax (
        .clk(clk), .rst(rst), .adv(dot_last), .last(h_last),
        .dend(act.hdend), .bstart(act.hbstart), .bend(act.hbend),
        .sstart(act.hsstart), .send(act.hsend),
        .cnt_o(h_cnt), .wrap_o(h_wrap), .active_o(h_act),
        .blank_o(h_blank), .sync_o(h_sync)
    );

    crtc_axis #(.REG_W(VREG_W), .CNT_W(VCNT_W), .BE_W(VBE_W), .SE_W(VSE_W)) u_vax (
        .clk(clk), .rst(rst), .adv(h_wrap), .last(v_last),
        .dend(act.vdend), .bstart(act.vbstart), .bend(act.vbend),
        .sstart(act.vsstart), .send(act.vsend),
        .cnt_o(v_cnt), .wrap_o(v_wrap), .active_o(v_act),
        .blank_o(v_blank), .sync_o(v_sync)
    );

    logic unused_cnt;
    assign unused_cnt = ^{h_cnt, v_cnt[VCNT_W-1]};

    assign disp     = h_act && v_act;
    assign de_o     = disp && !ctrl_q.scr_off;
    assign hblank_o = h_blank;
    assign vblank_o = v_blank;
    assign hsync_o  = (h_sync && !ctrl_q.hs_off) ^ ctrl_q.hneg;
    assign vsync_o  = (v_sync && !ctrl_q.vs_off) ^ ctrl_q.vneg;
    assign line_o   = v_cnt[VREG_W-1:0];

    always_comb begin
        status_o              = '0;
        status_o[SB_NODISP]   = !disp;
        status_o[SB_RETRACE]  = v_sync;
    end
endmodule

// File: rtl/crtc_timing_chk.sv
module crtc_timing_chk
    import crtc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              hsync_o,
    input logic              vsync_o,
    input logic              hblank_o,
    input logic              de_o,
    input logic [VREG_W-1:0] line_o,
    input logic [STAT_W-1:0] status_o,
    input crtc_ctrl_t        ctrl_q,
    input logic              dot_last,
    input logic              h_wrap
);
    assert_scr_off_R9: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.scr_off |-> !de_o);

    assert_hs_off_R9: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.hs_off |-> (hsync_o == ctrl_q.hneg));

    assert_vs_off_R9: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.vs_off |-> (vsync_o == ctrl_q.vneg));

    assert_retrace_R10: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.vs_off |-> (status_o[SB_RETRACE] == (vsync_o ^ ctrl_q.vneg)));

    assert_line_step_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(line_o) |-> (line_o == '0 || (line_o - $past(line_o)) == VREG_W'(1)));

    assert_line_at_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(line_o) |-> $past(h_wrap));

    assert_hblank_cell_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(hblank_o) |-> $past(dot_last));
endmodule

bind crtc_timing_gen crtc_timing_chk u_chk (
    .clk(clk), .rst(rst), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .hblank_o(hblank_o), .de_o(de_o), .line_o(line_o), .status_o(status_o),
    .ctrl_q(ctrl_q), .dot_last(dot_last), .h_wrap(h_wrap)
);

// File: tb/sim_crtc_timing_gen.sv
module sim_crtc_timing_gen;
    localparam int DOTS = 8;
    localparam int WDOG = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        hsync_o, vsync_o, hblank_o, vblank_o, de_o;
    logic [10:0] line_o;
    logic [7:0]  status_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;
    string phase = "R2";

    always #4 clk = ~clk;

    crtc_timing_gen u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .hblank_o(hblank_o), .vblank_o(vblank_o),
        .de_o(de_o), .line_o(line_o), .status_o(status_o)
    );

    // behavioural reference state
    int tm_act[12];
    int tm_pend[12];
    int mctrl, md, mhc, mvc;
    bit mhb, mhs, mvb, mvs;
    const int DEFS[12] = '{5, 5, 5, 9, 6, 8, 10, 7, 7, 11, 8, 10};

    function automatic int fmask(int a);
        case (a)
            3:       return 127;
            5:       return 31;
            9:       return 255;
            11:      return 15;
            0, 1, 2, 4: return 511;
            default: return 2047;
        endcase
    endfunction

    always @(posedge clk) begin
        bit dl, hw, fe;
        cyc <= cyc + 1;
        if (rst) begin
            for (int i = 0; i < 12; i++) begin tm_act[i] = DEFS[i]; tm_pend[i] = DEFS[i]; end
            mctrl = 0; md = 0; mhc = 0; mvc = 0;
            mhb = 0; mhs = 0; mvb = 0; mvs = 0;
        end else begin
            dl = (md == DOTS - 1);
            hw = dl && (mhc == tm_act[0] + 4);
            fe = hw && (mvc == tm_act[6] + 1);
            if (dl) begin
                if ((mhc % 128) == tm_act[3]) mhb = 0; else if (mhc == tm_act[2]) mhb = 1;
                if ((mhc % 32) == tm_act[5])  mhs = 0; else if (mhc == tm_act[4]) mhs = 1;
                mhc = hw ? 0 : mhc + 1;
            end
            if (hw) begin
                if ((mvc % 256) == tm_act[9]) mvb = 0; else if (mvc == tm_act[8]) mvb = 1;
                if ((mvc % 16) == tm_act[11]) mvs = 0; else if (mvc == tm_act[10]) mvs = 1;
                mvc = fe ? 0 : mvc + 1;
            end
            md = dl ? 0 : md + 1;
            if (fe) for (int i = 0; i < 12; i++) tm_act[i] = tm_pend[i];
            if (wr_en) begin
                if (wr_addr == 12) mctrl = wr_data & 255;
                else if (wr_addr < 12) tm_pend[wr_addr] = wr_data & fmask(int'(wr_addr));
            end
        end
    end

    task automatic chk(string req, string nm, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s [%s] %s got %0h expected %0h at cycle %0d", req, phase, nm, got, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        bit disp;
        int e_hs, e_vs;
        if (!rst && !done) begin
            disp = (mhc <= tm_act[1]) && (mvc <= tm_act[7]);
            e_hs = ((mhs && !(mctrl & 1)) ? 1 : 0) ^ ((mctrl >> 6) & 1);
            e_vs = ((mvs && !(mctrl & 2)) ? 1 : 0) ^ ((mctrl >> 7) & 1);
            chk("R2", "de_o", de_o, (disp && !(mctrl & 4)) ? 1 : 0);
            chk("R3", "hblank_o", hblank_o, mhb);
            chk("R4", "hsync_o", hsync_o, e_hs);
            chk("R5", "line_o", line_o, mvc % 2048);
            chk("R6", "vblank_o", vblank_o, mvb);
            chk("R7", "vsync_o", vsync_o, e_vs);
            chk("R10", "status_o", status_o, (mvs ? 8 : 0) | (disp ? 0 : 1));
        end
    end

    task automatic wr(int a, int d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run(int extra);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk + extra, n_fail + extra);
        $finish;
    endtask

    always @(posedge clk) if (cyc > WDOG && !done) begin
        $display("FAIL watchdog expired at cycle %0d", cyc);
        finish_run(1);
    end

    initial begin
        // R1: reset state observed while reset is held
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "de_o", de_o, 1);
        chk("R1", "hsync_o", hsync_o, 0);
        chk("R1", "vsync_o", vsync_o, 0);
        chk("R1", "hblank_o", hblank_o, 0);
        chk("R1", "vblank_o", vblank_o, 0);
        chk("R1", "line_o", line_o, 0);
        chk("R1", "status_o", status_o, 0);
        @(posedge clk); #1;
        rst = 1'b0;

        // default frame, two full frames
        phase = "R2";
        idle(2000);

        // R8: both syncs active-low
        phase = "R8";
        wr(12, 16'h00C0);
        idle(1000);

        // R9: hsync disabled, vsync active-low, then vsync disabled with retrace still on status
        phase = "R9";
        wr(12, 16'h0081);
        idle(1000);
        wr(12, 16'h0042);
        idle(1000);
        wr(12, 16'h0004);
        idle(600);
        wr(12, 16'h0000);

        // R11 / R12: new timing written mid-frame, end fields with extra high bits
        phase = "R11";
        idle(300);
        wr(0, 7);
        wr(1, 4);
        wr(2, 4);
        wr(3, 11 + 128);
        wr(4, 5);
        wr(5, 7 + 32);
        wr(6, 12);
        wr(7, 9);
        wr(8, 9);
        wr(9, 13 + 256);
        wr(10, 10);
        wr(11, 12 + 16);
        phase = "R12";
        idle(4500);

        // R11: timing write close to frame end, control write takes effect at once
        phase = "R11";
        wr(12, 16'h0040);
        wr(6, 11);
        idle(3000);

        finish_run(0);
    end
endmodule